// File: doc/BRIEF.md
# Detector Mismatch Interrupt Unit

This block turns two detector status lines, ring detect and carrier detect, into interrupts. Each line passes through a two-flop synchronizer. Its synchronized value is then compared with a compare bit that software writes. When the two differ, an interrupt flag is set. Software picks the transition it wants next by rewriting the compare bit. Copying the present status into the compare bit arms the logic for the next change away from that status. This lets one source interrupt both when a signal starts and when it ends.

The block also owns the demodulator enable. While the enable is set, the serial receiver input is taken from the demodulator output rather than the external receive pin. A `gpio_mode` output tells the pin logic to treat the four shared serial pins as general-purpose I/O. A stabilization state machine watches the oscillator run input and holds the enable off until the oscillator has been running long enough. The states are OSC_OFF, OSC_WARM and OSC_READY, with these transitions:
- OFF to WARM on `osc_run`.
- WARM to READY after `STAB_CYCLES` cycles in WARM.
- WARM or READY back to OFF whenever `osc_run` is low.

Software reaches the block through a simple strobe bus. Writes take effect at the clock edge. Read data is registered and appears one cycle after `rd_en`.

Top module: `det_irq_unit`

## Requirements
- R1: After reset the following are all zero: flags, compare bits, mask bits and enable. `irq` and `gpio_mode` are 0, and `ser_rx` follows `rx_pin`.
- R2: A change on `ring_det` or `carr_det` passes through a two-flop synchronizer. The synchronized status reflects a change two clock edges after it is sampled, and the flag can set no earlier than the third edge.
- R3: No flag is raised while a source's synchronized status equals its compare bit.
- R4: A flag is set at the edge after the cycle in which a status/compare mismatch first appears. For example, ring status going 0 to 1 with compare 0 sets the ring flag.
- R5: A flag stays set until a write to address 3 with a 1 in its bit (bit0 ring, bit1 carrier). Writing 0 has no effect. A new mismatch edge in the same cycle wins over the clear. The flag is not raised again while the same mismatch continues.
- R6: Writing the current status into the compare bit rearms the source. For example, ring compare 1 while ring is active raises the flag when ring returns to 0.
- R7: Carrier detect uses the same rule with its own compare bit, independently of ring.
- R8: `irq` is 1 exactly when some flag is set whose mask bit is 0. A masked source still sets its flag.
- R9: While the enable is 1, `ser_rx` equals `demod_out` and `gpio_mode` is 1. Otherwise `ser_rx` equals `rx_pin` and `gpio_mode` is 0.
- R10: The oscillator counts as ready after `STAB_CYCLES` cycles in warm-up, which begins with the first edge that sees `osc_run` high. Enable writes made while not ready are ignored. The enable clears whenever the oscillator is not ready.
- R11: The register map is as follows. Reads return data one cycle after `rd_en`.
  - Address 0: bit0 enable (read/write), bit1 ready (read only).
  - Address 1: compare bits, bit0 ring, bit1 carrier.
  - Address 2: mask bits (1 = masked), bit0 ring, bit1 carrier.
  - Address 3: reads bit0/bit1 as the ring/carrier flags and bit2/bit3 as the synchronized ring/carrier status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_det | input | 1 | Raw ring detector status |
| carr_det | input | 1 | Raw carrier detector status |
| osc_run | input | 1 | Oscillator is switched on |
| rx_pin | input | 1 | Serial receive data from the external pin |
| demod_out | input | 1 | Demodulated serial data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 2 | Write data |
| rdata | output | 4 | Registered read data |
| irq | output | 1 | Combined interrupt request |
| ser_rx | output | 1 | Data input to the serial receiver |
| gpio_mode | output | 1 | Shared serial pins act as general-purpose I/O |

## Verification
The hardest case to reach is a flag set and a software clear landing on the same edge. The mismatch only appears two edges after the raw input moves, so the clear has to be timed against the synchronizer delay. The bench reaches this by running long stretches of random detector toggles, interleaved with random clear, compare and mask writes, while the reference model decides every cycle. The oscillator gating is driven both before and after the stabilization count, including dropping `osc_run` while enabled.

// File: rtl/det_pkg.sv
package det_pkg;
    localparam int unsigned NSRC = 2;
    localparam int unsigned WD_W = 2;
    localparam int unsigned RD_W = 4;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CMP  = 2'd1;
    localparam logic [1:0] ADDR_MASK = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;

    typedef enum logic [1:0] {
        OSC_OFF   = 2'd0,
        OSC_WARM  = 2'd1,
        OSC_READY = 2'd2
    } osc_state_e;
endpackage

// File: rtl/det_sync.sv
module det_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/det_chan.sv
module det_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic cmp,
    input  logic clr,
    output logic stat,
    output logic flag
);
    logic mis;
    logic mis_q;
    logic set_now;

    det_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (stat)
    );

    always_comb begin
        mis     = stat ^ cmp;
        set_now = mis & ~mis_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mis_q <= 1'b0;
            flag  <= 1'b0;
        end else begin
            mis_q <= mis;
            flag  <= set_now | (flag & ~clr);
        end
    end

    AST_FLAG_ONLY_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(stat != cmp)); // R3
    AST_FLAG_FOLLOWS_NEW_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> mis_q); // R4
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_now) |=> !flag); // R5
endmodule

// File: rtl/osc_stab_fsm.sv
module osc_stab_fsm
    import det_pkg::*;
#(
    parameter int unsigned STAB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_run,
    output logic ready
);
    localparam int unsigned CW = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

    osc_state_e state, nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OSC_OFF;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state == OSC_WARM && nxt == OSC_WARM) ? cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            OSC_OFF:   nxt = osc_run ? OSC_WARM : OSC_OFF;
            OSC_WARM:  nxt = !osc_run ? OSC_OFF : ((cnt == LAST) ? OSC_READY : OSC_WARM);
            OSC_READY: nxt = osc_run ? OSC_READY : OSC_OFF;
            default:   nxt = OSC_OFF;
        endcase
    end

    always_comb begin
        ready = (state == OSC_READY);
    end

    AST_READY_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(osc_run)); // R10
endmodule

// File: rtl/det_irq_unit.sv
module det_irq_unit
    import det_pkg::*;
#(
    parameter int unsigned STAB_CYCLES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ring_det,
    input  logic            carr_det,
    input  logic            osc_run,
    input  logic            rx_pin,
    input  logic            demod_out,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [1:0]      addr,
    input  logic [WD_W-1:0] wdata,
    output logic [RD_W-1:0] rdata,
    output logic            irq,
    output logic            ser_rx,
    output logic            gpio_mode
);
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] cmp_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] stat;
    logic [NSRC-1:0] flag;
    logic [NSRC-1:0] clr;
    logic            en_q;
    logic            ready;
    logic            wr_ctrl, wr_cmp, wr_mask, wr_flag;
    logic [RD_W-1:0] rd_mux;

    assign raw = {carr_det, ring_det};

    always_comb begin
        wr_ctrl = wr_en && (addr == ADDR_CTRL);
        wr_cmp  = wr_en && (addr == ADDR_CMP);
        wr_mask = wr_en && (addr == ADDR_MASK);
        wr_flag = wr_en && (addr == ADDR_FLAG);
        clr     = wr_flag ? wdata[NSRC-1:0] : '0;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_chan
        det_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_in (raw[i]),
            .cmp    (cmp_q[i]),
            .clr    (clr[i]),
            .stat   (stat[i]),
            .flag   (flag[i])
        );
    end

    osc_stab_fsm #(.STAB_CYCLES(STAB_CYCLES)) u_osc (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_run (osc_run),
        .ready   (ready)
    );

    always_comb begin
        unique case (addr)
            ADDR_CTRL: rd_mux = {2'b00, ready, en_q};
            ADDR_CMP:  rd_mux = {2'b00, cmp_q};
            ADDR_MASK: rd_mux = {2'b00, mask_q};
            default:   rd_mux = {stat, flag};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            mask_q <= '0;
            en_q   <= 1'b0;
            rdata  <= '0;
        end else begin
            if (wr_cmp)  cmp_q  <= wdata[NSRC-1:0];
            if (wr_mask) mask_q <= wdata[NSRC-1:0];
            if (!ready)       en_q <= 1'b0;
            else if (wr_ctrl) en_q <= wdata[0];
            if (rd_en) rdata <= rd_mux;
        end
    end

    assign irq       = |(flag & ~mask_q);
    assign ser_rx    = en_q ? demod_out : rx_pin;
    assign gpio_mode = en_q;

    AST_EN_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> $past(ready)); // R10
    AST_MASKED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 2'b11) |-> !irq); // R8
endmodule

// File: tb/sim_det_irq_unit.sv
module sim_det_irq_unit;
    localparam int S = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ring_det = 0, carr_det = 0, osc_run = 0, rx_pin = 0, demod_out = 0;
    logic       wr_en = 0, rd_en = 0;
    logic [1:0] addr = 0;
    logic [1:0] wdata = 0;
    logic [3:0] rdata;
    logic       irq, ser_rx, gpio_mode;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_n = 0;

    det_irq_unit #(.STAB_CYCLES(S)) u0 (
        .clk(clk), .rst_n(rst_n), .ring_det(ring_det), .carr_det(carr_det),
        .osc_run(osc_run), .rx_pin(rx_pin), .demod_out(demod_out),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .ser_rx(ser_rx), .gpio_mode(gpio_mode)
    );

    always #2.5 clk = ~clk;

    // reference model
    int m_s1 [2], m_s2 [2], m_cmp [2], m_msk [2], m_flg [2], m_prev [2];
    int m_en, m_runs, m_rdata;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_cmp[i] = 0; m_msk[i] = 0; m_flg[i] = 0; m_prev[i] = 0;
            end
            m_en = 0; m_runs = 0; m_rdata = 0;
        end else begin
            int rdy, raw [2], diff, nrd;
            rdy = (m_runs > S);
            raw[0] = ring_det; raw[1] = carr_det;
            case (addr)
                2'd0: nrd = rdy * 2 + m_en;
                2'd1: nrd = m_cmp[1] * 2 + m_cmp[0];
                2'd2: nrd = m_msk[1] * 2 + m_msk[0];
                default: nrd = m_s2[1] * 8 + m_s2[0] * 4 + m_flg[1] * 2 + m_flg[0];
            endcase
            if (rd_en) m_rdata = nrd;
            for (int i = 0; i < 2; i++) begin
                diff = (m_s2[i] != m_cmp[i]);
                if (wr_en && addr == 2'd3 && wdata[i]) m_flg[i] = 0;
                if (diff && !m_prev[i]) m_flg[i] = 1;
                m_prev[i] = diff;
                m_s2[i] = m_s1[i];
                m_s1[i] = raw[i];
            end
            if (!rdy) m_en = 0;
            else if (wr_en && addr == 2'd0) m_en = wdata[0];
            if (wr_en && addr == 2'd1) begin m_cmp[0] = wdata[0]; m_cmp[1] = wdata[1]; end
            if (wr_en && addr == 2'd2) begin m_msk[0] = wdata[0]; m_msk[1] = wdata[1]; end
            m_runs = osc_run ? m_runs + 1 : 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        int e_irq, e_rx;
        e_irq = (m_flg[0] && !m_msk[0]) || (m_flg[1] && !m_msk[1]);
        e_rx  = m_en ? demod_out : rx_pin;
        chk(irq == e_irq, "R8", "irq", irq, e_irq);
        chk(ser_rx == e_rx, "R9", "ser_rx", ser_rx, e_rx);
        chk(gpio_mode == m_en, "R9", "gpio_mode", gpio_mode, m_en);
        chk(rdata == m_rdata, "R11", "rdata", rdata, m_rdata);
    endtask

    task automatic cyc();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] d);
        wr_en = 1; addr = a; wdata = d;
        cyc();
        wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [3:0] d);
        rd_en = 1; addr = a;
        cyc();
        rd_en = 0;
        d = rdata;
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 50000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        logic [3:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc();
        // R1 reset state
        chk(irq == 0 && gpio_mode == 0, "R1", "irq/gpio after reset", {irq, gpio_mode}, 0);
        rx_pin = 1; cyc();
        chk(ser_rx == 1, "R1", "ser_rx follows pin", ser_rx, 1);
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            chk(d == 0, "R1", "register zero after reset", d, 0);
        end
        // R3 equal -> no flag
        repeat (5) cyc();
        chk(irq == 0, "R3", "no irq while equal", irq, 0);
        // R2 / R4 ring rise
        ring_det = 1;
        cyc(); cyc();
        chk(irq == 0, "R2", "irq not before sync delay", irq, 0);
        cyc();
        chk(irq == 1, "R4", "ring flag on mismatch", irq, 1);
        rd(2'd3, d);
        chk(d == 4'b0101, "R11", "flag reg ring", d, 4'b0101);
        // R5 write 0 no effect, write 1 clears, no re-raise
        wr(2'd3, 2'b00); cyc();
        chk(irq == 1, "R5", "write 0 keeps flag", irq, 1);
        wr(2'd3, 2'b01); cyc();
        chk(irq == 0, "R5", "clear by write 1", irq, 0);
        repeat (4) cyc();
        chk(irq == 0, "R5", "no re-raise same mismatch", irq, 0);
        // R6 copy status to compare, fire on ring end
        wr(2'd1, 2'b01); repeat (3) cyc();
        chk(irq == 0, "R6", "no irq after rearm", irq, 0);
        ring_det = 0; repeat (3) cyc();
        chk(irq == 1, "R6", "irq when ring ends", irq, 1);
        wr(2'd3, 2'b01); wr(2'd1, 2'b00); cyc();
        // R7 + R8 carrier masked
        wr(2'd2, 2'b10);
        carr_det = 1; repeat (3) cyc();
        chk(irq == 0, "R8", "masked carrier no irq", irq, 0);
        rd(2'd3, d);
        chk(d == 4'b1010, "R7", "carrier flag set while masked", d, 4'b1010);
        wr(2'd2, 2'b00);
        chk(irq == 1, "R8", "unmask asserts irq", irq, 1);
        wr(2'd3, 2'b10); wr(2'd1, 2'b10);
        carr_det = 0; repeat (3) cyc();
        chk(irq == 1, "R7", "carrier end irq", irq, 1);
        wr(2'd3, 2'b11); wr(2'd1, 2'b00); cyc();
        // R10 enable before ready ignored
        wr(2'd0, 2'b01); cyc();
        chk(gpio_mode == 0, "R10", "enable ignored with osc off", gpio_mode, 0);
        osc_run = 1; repeat (8) cyc();
        wr(2'd0, 2'b01); cyc();
        chk(gpio_mode == 0, "R10", "enable ignored in warm-up", gpio_mode, 0);
        repeat (S) cyc();
        rd(2'd0, d);
        chk(d == 4'b0010, "R10", "ready bit", d, 4'b0010);
        wr(2'd0, 2'b01);
        chk(gpio_mode == 1, "R9", "enable takes", gpio_mode, 1);
        demod_out = 1; rx_pin = 0; cyc();
        chk(ser_rx == 1, "R9", "ser_rx from demod", ser_rx, 1);
        demod_out = 0; rx_pin = 1; cyc();
        chk(ser_rx == 0, "R9", "ser_rx from demod 0", ser_rx, 0);
        osc_run = 0; cyc(); cyc();
        chk(gpio_mode == 0, "R10", "enable cleared on osc stop", gpio_mode, 0);
        // random phase
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom;
            if (r[2:0] == 0) ring_det = ~ring_det;
            if (r[5:3] == 0) carr_det = ~carr_det;
            rx_pin = r[6]; demod_out = r[7];
            if (r[15:8] == 0) osc_run = ~osc_run;
            wr_en = (r[18:16] == 0);
            rd_en = r[19];
            addr  = r[21:20];
            wdata = r[23:22];
            cyc();
        end
        wr_en = 0; rd_en = 0;
        cyc();
        finish_up();
    end
endmodule